// File: doc/BRIEF.md
# Bounded-Weight Bit-Flip Mask Generator

This block produces, one per handshake, every distinct 32-bit flip mask with one to four bits set. It also applies each mask to a captured target word, so the consumer receives the corrupted word that results from inverting exactly those bits. A single pulse on `start` captures the target and begins the sweep. The consumer takes each mask through a ready/valid handshake and may stall for any number of cycles.

Masks come out grouped by weight, lightest first. Inside one weight the bit positions form a strictly increasing tuple, and successive tuples follow lexicographic order. Because the tuple is strictly increasing, no mask is ever produced twice and the all-zero mask is never produced. A running count shows how many masks have been accepted since the last start. A done flag rises once the final mask has been taken. A start pulse restarts the sweep at any time, whether the block is idle, mid-sweep or finished.

Top module: `flipmask_gen`

## Requirements
- R1: After reset, `validOut` and `doneOut` are 0 and `countOut` is 0.
- R2: In the cycle after `start` is sampled high, `validOut` is 1, `maskOut` is 0x00000001, `countOut` is 0 and `doneOut` is 0.
- R3: While `validOut` is 1, `candOut` equals the target word captured at start XOR `maskOut`.
- R4: Masks appear in weight order 1, 2, 3, 4. Inside a weight, the set-bit positions i<j<k<l step in lexicographic order. For example, index 31 gives 0x80000000, index 32 gives 0x00000003, index 62 gives 0x80000001, index 528 gives 0x00000007 and index 5488 gives 0x0000000F.
- R5: Every mask has between one and four bits set, and no mask repeats within one sweep.
- R6: Exactly 41448 masks are produced. In the cycle after the last one (0xF0000000) is accepted, `doneOut` is 1, `validOut` is 0 and `countOut` is 41448.
- R7: While `validOut` is 1 and `readyIn` is 0, `maskOut`, `candOut` and `countOut` hold their values.
- R8: A `start` pulse in any state, including mid-sweep and after done, restarts the sweep from the first mask with the count at zero.
- R9: `countOut` increments by one on each accepted mask, so it equals the number of masks accepted since the last start.
- R10: Changes on `targetIn` while `start` is low do not affect `candOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the target and restarts the sweep |
| targetIn | input | 32 | Word to be corrupted, sampled on start |
| readyIn | input | 1 | Consumer accepts the current mask |
| validOut | output | 1 | A mask and candidate are presented |
| maskOut | output | 32 | Current flip mask |
| candOut | output | 32 | Target word with the mask bits inverted |
| countOut | output | 16 | Masks accepted since the last start |
| doneOut | output | 1 | Sweep complete |

## Verification
A fault in the index registers shows at the ports within one accepted mask. A repeated, skipped or out-of-order tuple changes `maskOut` away from the value that the independent nested-loop model expects at that index. A broken end-of-weight test makes the sweep move to the next weight too early or too late, so the count at `doneOut` is no longer 41448. A stall that leaks an advance shows as a mask changing while `readyIn` is low.

// File: rtl/flipmask_pkg.sv
package flipmask_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } sweepState_t;

  function automatic int binom(input int n, input int k);
    int res;
    res = 1;
    for (int i = 0; i < k; i++) begin
      res = res * (n - i) / (i + 1);
    end
    return res;
  endfunction

  function automatic int sweepTotal(input int wordW, input int maxWt);
    int acc;
    acc = 0;
    for (int w = 1; w <= maxWt; w++) begin
      acc = acc + binom(wordW, w);
    end
    return acc;
  endfunction

endpackage

// File: rtl/flipmask_dp.sv
module flipmask_dp
  import flipmask_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int MAX_WT = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [WORD_W-1:0] targetIn,
  output logic [WORD_W-1:0] maskOut,
  output logic [WORD_W-1:0] candOut,
  output logic [CNT_W-1:0]  countOut,
  output logic              isLast
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam int WT_W  = $clog2(MAX_WT + 2);

  logic [IDX_W-1:0]  idxQ [MAX_WT];
  logic [IDX_W-1:0]  idxN [MAX_WT];
  logic [WT_W-1:0]   wtQ, wtN;
  logic [WORD_W-1:0] targetQ;
  logic [CNT_W-1:0]  countQ;
  logic              found;
  int                pivot;

  // Successor tuple: bump the rightmost index that still has room,
  // then pack the following indices tightly above it.
  always_comb begin
    found = 1'b0;
    pivot = 0;
    wtN   = wtQ;
    for (int p = 0; p < MAX_WT; p++) begin
      idxN[p] = idxQ[p];
      if (p < int'(wtQ) && int'(idxQ[p]) < WORD_W - int'(wtQ) + p) begin
        found = 1'b1;
        pivot = p;
      end
    end
    if (found) begin
      for (int q = 0; q < MAX_WT; q++) begin
        if (q >= pivot) begin
          idxN[q] = IDX_W'(int'(idxQ[pivot]) + 1 + q - pivot);
        end
      end
    end else begin
      wtN = wtQ + WT_W'(1);
      for (int q = 0; q < MAX_WT; q++) begin
        idxN[q] = IDX_W'(q);
      end
    end
    isLast = !found && (int'(wtQ) == MAX_WT);
  end

  always_comb begin
    maskOut = '0;
    for (int q = 0; q < MAX_WT; q++) begin
      if (q < int'(wtQ)) begin
        maskOut[idxQ[q]] = 1'b1;
      end
    end
  end

  assign candOut  = targetQ ^ maskOut;
  assign countOut = countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int q = 0; q < MAX_WT; q++) idxQ[q] <= '0;
      wtQ     <= '0;
      targetQ <= '0;
      countQ  <= '0;
    end else if (ctl.load) begin
      for (int q = 0; q < MAX_WT; q++) idxQ[q] <= IDX_W'(q);
      wtQ     <= WT_W'(1);
      targetQ <= targetIn;
      countQ  <= '0;
    end else if (ctl.step) begin
      for (int q = 0; q < MAX_WT; q++) idxQ[q] <= idxN[q];
      wtQ    <= wtN;
      countQ <= countQ + CNT_W'(1);
    end
  end

  // R5: active indices stay strictly increasing, so no duplicate bit
  generate
    for (genvar g = 0; g + 1 < MAX_WT; g++) begin : g_order
      p_strict_order_r5: assert property (@(posedge clk) disable iff (!rstN)
        (int'(wtQ) > g + 1 && int'(wtQ) <= MAX_WT) |-> (idxQ[g] < idxQ[g+1]));
    end
  endgenerate

  // R5: mask weight matches the active weight in range 1..MAX_WT
  p_weight_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wtQ != '0 && int'(wtQ) <= MAX_WT) |-> ($countones(maskOut) == int'(wtQ)));

  // R9: each step adds exactly one to the count
  p_count_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.load) |=> (countQ == $past(countQ) + CNT_W'(1)));

  // R10: captured target is untouched between loads
  p_target_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> $stable(targetQ));

endmodule

// File: rtl/flipmask_ctl.sv
module flipmask_ctl
  import flipmask_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        readyIn,
  input  logic        isLast,
  output ctlStrobes_t ctl,
  output logic        validOut,
  output logic        doneOut
);

  sweepState_t stateQ, stateN;
  logic        accept;

  assign validOut = (stateQ == ST_RUN);
  assign doneOut  = (stateQ == ST_DONE);
  assign accept   = validOut && readyIn;

  assign ctl.load = start;
  assign ctl.step = accept && !start;

  always_comb begin
    stateN = stateQ;
    if (start) begin
      stateN = ST_RUN;
    end else if (accept && isLast) begin
      stateN = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateN;
  end

  // R2: start always leads to a presented mask
  p_start_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (validOut && !doneOut));

  // R6: taking the final mask finishes the sweep
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && isLast && !start) |=> (doneOut && !validOut));

  // R7: a stalled mask stays presented
  p_stall_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !readyIn && !start) |=> validOut);

endmodule

// File: rtl/flipmask_gen.sv
module flipmask_gen
  import flipmask_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int MAX_WT = 4,
  parameter int CNT_W  = $clog2(sweepTotal(WORD_W, MAX_WT) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [WORD_W-1:0] targetIn,
  input  logic              readyIn,
  output logic              validOut,
  output logic [WORD_W-1:0] maskOut,
  output logic [WORD_W-1:0] candOut,
  output logic [CNT_W-1:0]  countOut,
  output logic              doneOut
);

  localparam int TOTAL = sweepTotal(WORD_W, MAX_WT);

  ctlStrobes_t ctl;
  logic        isLast;

  flipmask_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .readyIn  (readyIn),
    .isLast   (isLast),
    .ctl      (ctl),
    .validOut (validOut),
    .doneOut  (doneOut)
  );

  flipmask_dp #(
    .WORD_W (WORD_W),
    .MAX_WT (MAX_WT),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .targetIn (targetIn),
    .maskOut  (maskOut),
    .candOut  (candOut),
    .countOut (countOut),
    .isLast   (isLast)
  );

  // R7: stalled outputs hold
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && !readyIn && !start) |=> ($stable(maskOut) && $stable(candOut) && $stable(countOut)));

  // R6: done only with the full count
  p_done_total_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |-> (int'(countOut) == TOTAL));

  // R5: a presented mask is never zero
  p_nonzero_r5: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (maskOut != '0));

endmodule

// File: tb/flipmask_gen_bench.sv
module flipmask_gen_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] targetIn = '0;
  logic        readyIn = 1'b0;
  logic        validOut;
  logic [31:0] maskOut;
  logic [31:0] candOut;
  logic [15:0] countOut;
  logic        doneOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flipmask_gen u_flipmask_gen (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .targetIn (targetIn),
    .readyIn  (readyIn),
    .validOut (validOut),
    .maskOut  (maskOut),
    .candOut  (candOut),
    .countOut (countOut),
    .doneOut  (doneOut)
  );

  // {sweep index, expected mask}
  localparam logic [47:0] VEC [10] = '{
    {16'd0,     32'h0000_0001},
    {16'd5,     32'h0000_0020},
    {16'd31,    32'h8000_0000},
    {16'd32,    32'h0000_0003},
    {16'd62,    32'h8000_0001},
    {16'd63,    32'h0000_0006},
    {16'd528,   32'h0000_0007},
    {16'd5487,  32'hE000_0000},
    {16'd5488,  32'h0000_000F},
    {16'd41447, 32'hF000_0000}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic doStart(input logic [31:0] t);
    @(negedge clk);
    start = 1'b1;
    targetIn = t;
    readyIn = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  // sequence checking with a stalling consumer
  int phase = 0;
  int accepted = 0;
  int mism = 0;
  logic [31:0] seqTarget;

  task automatic expectNext(input logic [31:0] m);
    bit took;
    took = 0;
    while (!took) begin
      @(negedge clk);
      phase++;
      readyIn = (phase % 3 != 0);
      if (readyIn) begin
        if (!validOut || maskOut !== m || candOut !== (seqTarget ^ m) || int'(countOut) != accepted) begin
          if (mism == 0)
            $display("FAIL R4 index %0d actual=%h expected=%h count=%0d", accepted, maskOut, m, countOut);
          mism++;
        end
        accepted++;
        took = 1;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    int cur;
    logic [31:0] t1, t2, t3;
    t1 = 32'hA5A5_0F0F;
    t2 = 32'h1234_5678;
    t3 = 32'h0F0F_F0F0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(validOut == 1'b0, "R1 valid", {31'd0, validOut}, 32'd0);
    check(doneOut == 1'b0, "R1 done", {31'd0, doneOut}, 32'd0);
    check(countOut == 16'd0, "R1 count", {16'd0, countOut}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(validOut == 1'b0, "R1 idle valid", {31'd0, validOut}, 32'd0);

    // R2 start, then table walk with ready held high (R3, R4, R9)
    doStart(t1);
    check(validOut && !doneOut && maskOut == 32'h1 && countOut == 16'd0, "R2 first mask", maskOut, 32'h1);
    readyIn = 1'b1;
    cur = 0;
    foreach (VEC[e]) begin
      while (cur < int'(VEC[e][47:32])) begin
        @(negedge clk);
        cur++;
      end
      check(validOut && maskOut == VEC[e][31:0], "R4 table mask", maskOut, VEC[e][31:0]);
      check(candOut == (t1 ^ VEC[e][31:0]), "R3 candidate", candOut, t1 ^ VEC[e][31:0]);
      check(int'(countOut) == cur, "R9 count", {16'd0, countOut}, cur);
    end
    // R6 done in the cycle after the last accept
    @(negedge clk);
    check(doneOut && !validOut, "R6 done", {30'd0, doneOut, validOut}, 32'h2);
    check(countOut == 16'd41448, "R6 total", {16'd0, countOut}, 32'd41448);
    readyIn = 1'b0;

    // R8 restart from done
    doStart(t2);
    check(validOut && !doneOut && maskOut == 32'h1 && countOut == 16'd0, "R8 restart after done", maskOut, 32'h1);
    readyIn = 1'b1;
    repeat (4) @(negedge clk);
    readyIn = 1'b0;
    check(maskOut == 32'h10 && countOut == 16'd4, "R9 four accepts", maskOut, 32'h10);
    // R7 stall
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      check(validOut && maskOut == 32'h10 && candOut == (t2 ^ 32'h10) && countOut == 16'd4,
            "R7 stall hold", maskOut, 32'h10);
    end
    // R10 target change without start
    targetIn = 32'hFFFF_FFFF;
    repeat (2) @(negedge clk);
    check(candOut == (t2 ^ 32'h10), "R10 target ignored", candOut, t2 ^ 32'h10);
    readyIn = 1'b1;
    @(negedge clk);
    check(candOut == (t2 ^ 32'h20), "R10 target ignored after step", candOut, t2 ^ 32'h20);
    readyIn = 1'b0;

    // R8 restart mid-sweep
    doStart(t3);
    check(maskOut == 32'h1 && countOut == 16'd0 && candOut == (t3 ^ 32'h1), "R8 restart mid-sweep", maskOut, 32'h1);

    // R4 R5 R9 full sequence with a stalling consumer, against nested loops
    seqTarget = t3;
    for (int a = 0; a < 32; a++) expectNext(32'h1 << a);
    for (int a = 0; a < 32; a++)
      for (int b = a + 1; b < 32; b++) expectNext((32'h1 << a) | (32'h1 << b));
    for (int a = 0; a < 32; a++)
      for (int b = a + 1; b < 32; b++)
        for (int c = b + 1; c < 32; c++) expectNext((32'h1 << a) | (32'h1 << b) | (32'h1 << c));
    for (int a = 0; a < 32; a++)
      for (int b = a + 1; b < 32; b++)
        for (int c = b + 1; c < 32; c++)
          for (int d = c + 1; d < 32; d++)
            expectNext((32'h1 << a) | (32'h1 << b) | (32'h1 << c) | (32'h1 << d));
    check(mism == 0, "R4 R5 full order", mism, 32'd0);
    @(negedge clk);
    readyIn = 1'b0;
    check(doneOut && !validOut && countOut == 16'd41448, "R6 done after stalled sweep", {16'd0, countOut}, 32'd41448);
    @(negedge clk);
    check(doneOut && countOut == 16'd41448, "R6 done holds", {16'd0, countOut}, 32'd41448);

    finishRun();
  end

endmodule